// File: doc/BRIEF.md
# Low-Power Radix-2 Decimation-in-Time Butterfly

This block computes one radix-2 decimation-in-time butterfly on fixed-point complex samples. Each accepted transfer carries two complex operands A and B and a twiddle index k. The block forms the twiddled term W·B, where W is taken from an internal coefficient table. It then returns the sum X0 = A + W·B and the difference X1 = A − W·B. The block is the arithmetic core of an FFT engine. The engine that surrounds it handles sequencing, addressing and reordering.

The complex product uses three real multipliers instead of four. For each index the table holds the real part c of the twiddle together with the pre-combined terms (d − c) and (c + d), so the coefficient side needs no adder at run time. Every output component comes from four operands: the aligned A term, two products and one constant that merges the rounding half-LSB with the two's-complement carry-ins. A 4:2 compressor, built from two 3:2 rows, reduces these four operands to a carry-save pair. One carry-propagate adder per component follows, and then rounding and saturation.

There are three pipeline stages: multiply, compress, then add and saturate. A valid bit travels with the data. Every stage is held whenever the downstream side is not ready. Data registers load only when the stage receives a valid item, which keeps switching activity low in idle cycles.

Top module: `r2_butterfly_lp`

## Requirements
- R1: For index k the twiddle is W = c + j·d, with c = round(cos(2πk/NFFT)·2^(DW−1)) and d = round(−sin(2πk/NFFT)·2^(DW−1)), rounding half away from zero and held exactly in DW+1 bits. The block returns X0 = A + W·B and X1 = A − W·B, where the exact product terms are Pre = c·Bre − d·Bim and Pim = c·Bim + d·Bre.
- R2: Each output component equals floor((Acomp·2^(DW−1) ± Pcomp + 2^(DW−2)) / 2^(DW−1)), which rounds to nearest with halves going up. The sign is + for X0 and − for X1.
- R3: A component that falls outside the signed DW-bit range is clamped to 2^(DW−1)−1 or −2^(DW−1). It does not wrap.
- R4: Index 0 gives W = 1 exactly, so X0 = A + B and X1 = A − B, subject only to R3.
- R5: A transfer accepted at a clock edge (in_valid and in_ready both high) appears with out_valid high after the third rising edge, provided out_ready stays high. out_valid is low before that edge.
- R6: While out_ready is low, in_ready is low. No input is taken, and out_valid and all four outputs hold their values. Inputs offered during the stall are not taken.
- R7: After reset, out_valid is low until a transfer has passed through all three stages.
- R8: When no component of a result is clamped, (X0 + X1 − 2·A) is 0 or 1 for both the real and the imaginary part.
- R9: Full-scale negative operands (−2^(DW−1) in any component) give exact results under R2 and R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input transfer offered |
| in_ready | output | 1 | Input transfer can be taken this cycle |
| in_are | input | DW | Real part of A, signed |
| in_aim | input | DW | Imaginary part of A, signed |
| in_bre | input | DW | Real part of B, signed |
| in_bim | input | DW | Imaginary part of B, signed |
| in_idx | input | $clog2(NFFT/2) | Twiddle index k |
| out_valid | output | 1 | Result present on the outputs |
| out_ready | input | 1 | Downstream accepts; advances every stage |
| x0_re | output | DW | Real part of A + W·B |
| x0_im | output | DW | Imaginary part of A + W·B |
| x1_re | output | DW | Real part of A − W·B |
| x1_im | output | DW | Imaginary part of A − W·B |

## Verification
The hardest situation to reach is a stall that holds a finished result at the outputs while new, conflicting operands are offered at the input. The bench first drives one transfer all the way to the output stage. It then drops out_ready and presents a different vector with in_valid high for several cycles. When it releases the stall with in_valid low, it expects the held result to drain and no trace of the offered vector to appear. The rounding ties and the saturation limits are reached with full-scale negative and full-scale positive operands at index 0, with the 45-degree and quarter-turn twiddles, and with a long pseudo-random sweep over every index.

// File: rtl/r2bf_pkg.sv
package r2bf_pkg;

  // Fixed-point twiddle component: cos (sin_part=0) or -sin (sin_part=1),
  // scaled by 2^fb and rounded half away from zero.
  function automatic longint tw_fixed(int k, int n, int fb, bit sin_part);
    real ang;
    real v;
    ang = 2.0 * 3.141592653589793 * real'(k) / real'(n);
    v = sin_part ? -$sin(ang) : $cos(ang);
    for (int i = 0; i < fb; i++) v = v * 2.0;
    if (v >= 0.0) return longint'($rtoi(v + 0.5));
    return longint'($rtoi(v - 0.5));
  endfunction

endpackage

// File: rtl/r2bf_twiddle_rom.sv
module r2bf_twiddle_rom
  import r2bf_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NFFT = 16
) (
  input  logic [$clog2(NFFT/2)-1:0] idx,
  output logic signed [DW:0]        coef_c,
  output logic signed [DW:0]        coef_dmc,
  output logic signed [DW:0]        coef_cpd
);
  localparam int NTW = NFFT / 2;
  localparam int CW  = DW + 1;
  localparam int FB  = DW - 1;

  logic signed [CW-1:0] tab_c   [NTW];
  logic signed [CW-1:0] tab_dmc [NTW];
  logic signed [CW-1:0] tab_cpd [NTW];

  for (genvar k = 0; k < NTW; k++) begin : g_entry
    localparam longint CV = tw_fixed(k, NFFT, FB, 1'b0);
    localparam longint DV = tw_fixed(k, NFFT, FB, 1'b1);
    assign tab_c[k]   = CW'(CV);
    assign tab_dmc[k] = CW'(DV - CV);
    assign tab_cpd[k] = CW'(CV + DV);
  end

  assign coef_c   = tab_c[idx];
  assign coef_dmc = tab_dmc[idx];
  assign coef_cpd = tab_cpd[idx];
endmodule

// File: rtl/r2bf_cmul3.sv
module r2bf_cmul3 #(
  parameter int DW = 16,
  parameter int SW = 34
) (
  input  logic signed [DW-1:0] b_re,
  input  logic signed [DW-1:0] b_im,
  input  logic signed [DW:0]   coef_c,
  input  logic signed [DW:0]   coef_dmc,
  input  logic signed [DW:0]   coef_cpd,
  output logic signed [SW-1:0] k1,
  output logic signed [SW-1:0] k2,
  output logic signed [SW-1:0] k3
);
  localparam int CW = DW + 1;

  logic signed [DW:0]   bsum;
  logic signed [SW-1:0] bsum_x, bre_x, bim_x, c_x, dmc_x, cpd_x;

  assign bsum   = {b_re[DW-1], b_re} + {b_im[DW-1], b_im};
  assign bsum_x = {{(SW-DW-1){bsum[DW]}}, bsum};
  assign bre_x  = {{(SW-DW){b_re[DW-1]}}, b_re};
  assign bim_x  = {{(SW-DW){b_im[DW-1]}}, b_im};
  assign c_x    = {{(SW-CW){coef_c[CW-1]}}, coef_c};
  assign dmc_x  = {{(SW-CW){coef_dmc[CW-1]}}, coef_dmc};
  assign cpd_x  = {{(SW-CW){coef_cpd[CW-1]}}, coef_cpd};

  // three real products
  assign k1 = c_x * bsum_x;
  assign k2 = dmc_x * bre_x;
  assign k3 = cpd_x * bim_x;
endmodule

// File: rtl/r2bf_csa32.sv
module r2bf_csa32 #(
  parameter int SW = 34
) (
  input  logic [SW-1:0] a,
  input  logic [SW-1:0] b,
  input  logic [SW-1:0] c,
  output logic [SW-1:0] s,
  output logic [SW-1:0] cy
);
  assign s  = a ^ b ^ c;
  assign cy = ((a & b) | (a & c) | (b & c)) << 1;
endmodule

// File: rtl/r2bf_csa42.sv
module r2bf_csa42 #(
  parameter int SW = 34
) (
  input  logic [SW-1:0] w,
  input  logic [SW-1:0] x,
  input  logic [SW-1:0] y,
  input  logic [SW-1:0] z,
  output logic [SW-1:0] s,
  output logic [SW-1:0] cy
);
  logic [SW-1:0] s1, c1;

  r2bf_csa32 #(.SW(SW)) u_row1 (.a(w),  .b(x),  .c(y), .s(s1), .cy(c1));
  r2bf_csa32 #(.SW(SW)) u_row2 (.a(s1), .b(c1), .c(z), .s(s),  .cy(cy));
endmodule

// File: rtl/r2_butterfly_lp.sv
module r2_butterfly_lp
  import r2bf_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NFFT = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [DW-1:0]             in_are,
  input  logic [DW-1:0]             in_aim,
  input  logic [DW-1:0]             in_bre,
  input  logic [DW-1:0]             in_bim,
  input  logic [$clog2(NFFT/2)-1:0] in_idx,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [DW-1:0]             x0_re,
  output logic [DW-1:0]             x0_im,
  output logic [DW-1:0]             x1_re,
  output logic [DW-1:0]             x1_im
);
  localparam int SW = 2 * DW + 2;
  localparam int FB = DW - 1;
  localparam int NL = 4;
  localparam int XT = SW - DW - FB;

  localparam logic [SW-1:0] HALF  = {{(SW-DW+1){1'b0}}, 1'b1, {(DW-2){1'b0}}};
  localparam logic [SW-1:0] HALF1 = HALF + SW'(1);
  localparam logic [SW-1:0] HALF2 = HALF + SW'(2);
  localparam logic signed [SW-1:0] SAT_HI = {{(SW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [SW-1:0] SAT_LO = {{(SW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  // ---------------- handshake / enables
  logic adv, ld1, ld2, ld3;
  logic v1_q, v2_q, v3_q, v1_d, v2_d, v3_d;

  assign adv      = out_ready;
  assign in_ready = out_ready;
  assign ld1      = adv & in_valid;
  assign ld2      = adv & v1_q;
  assign ld3      = adv & v2_q;

  always_comb begin
    v1_d = v1_q;
    v2_d = v2_q;
    v3_d = v3_q;
    if (adv) begin
      v1_d = in_valid;
      v2_d = v1_q;
      v3_d = v2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      v3_q <= 1'b0;
    end else begin
      v1_q <= v1_d;
      v2_q <= v2_d;
      v3_q <= v3_d;
    end
  end

  // ---------------- stage 1: coefficient lookup and three products
  logic signed [DW:0]   coef_c, coef_dmc, coef_cpd;
  logic signed [SW-1:0] k1_d, k2_d, k3_d;
  logic signed [SW-1:0] k1_q, k2_q, k3_q;
  logic signed [DW-1:0] are_q, aim_q;

  r2bf_twiddle_rom #(.DW(DW), .NFFT(NFFT)) u_rom (
    .idx     (in_idx),
    .coef_c  (coef_c),
    .coef_dmc(coef_dmc),
    .coef_cpd(coef_cpd)
  );

  r2bf_cmul3 #(.DW(DW), .SW(SW)) u_cmul (
    .b_re    (in_bre),
    .b_im    (in_bim),
    .coef_c  (coef_c),
    .coef_dmc(coef_dmc),
    .coef_cpd(coef_cpd),
    .k1      (k1_d),
    .k2      (k2_d),
    .k3      (k3_d)
  );

  always_ff @(posedge clk) begin
    if (ld1) begin
      k1_q  <= k1_d;
      k2_q  <= k2_d;
      k3_q  <= k3_d;
      are_q <= in_are;
      aim_q <= in_aim;
    end
  end

  // ---------------- stage 2: four-operand carry-save reduction per lane
  // lane 0: X0 real, 1: X0 imag, 2: X1 real, 3: X1 imag
  logic [SW-1:0] are_sh, aim_sh;
  logic [SW-1:0] opw [NL];
  logic [SW-1:0] opx [NL];
  logic [SW-1:0] opy [NL];
  logic [SW-1:0] opz [NL];
  logic [SW-1:0] cs_s_d [NL];
  logic [SW-1:0] cs_c_d [NL];
  logic [SW-1:0] cs_s_q [NL];
  logic [SW-1:0] cs_c_q [NL];

  assign are_sh = {{XT{are_q[DW-1]}}, are_q, {FB{1'b0}}};
  assign aim_sh = {{XT{aim_q[DW-1]}}, aim_q, {FB{1'b0}}};

  always_comb begin
    // real part of W*B is k1 - k3, imaginary part is k1 + k2;
    // inversions take their +1 from the constant operand
    opw[0] = are_sh; opx[0] = k1_q;  opy[0] = ~k3_q; opz[0] = HALF1;
    opw[1] = aim_sh; opx[1] = k1_q;  opy[1] = k2_q;  opz[1] = HALF;
    opw[2] = are_sh; opx[2] = ~k1_q; opy[2] = k3_q;  opz[2] = HALF1;
    opw[3] = aim_sh; opx[3] = ~k1_q; opy[3] = ~k2_q; opz[3] = HALF2;
  end

  for (genvar l = 0; l < NL; l++) begin : g_cmp
    r2bf_csa42 #(.SW(SW)) u_csa (
      .w (opw[l]),
      .x (opx[l]),
      .y (opy[l]),
      .z (opz[l]),
      .s (cs_s_d[l]),
      .cy(cs_c_d[l])
    );

    always_ff @(posedge clk) begin
      if (ld2) begin
        cs_s_q[l] <= cs_s_d[l];
        cs_c_q[l] <= cs_c_d[l];
      end
    end
  end

  // ---------------- stage 3: carry-propagate add, scale, saturate
  logic [DW-1:0] res_d [NL];
  logic [DW-1:0] res_q [NL];

  for (genvar l = 0; l < NL; l++) begin : g_cpa
    logic signed [SW-1:0] tot, shf;
    assign tot = cs_s_q[l] + cs_c_q[l];
    assign shf = tot >>> FB;

    always_comb begin
      if (shf > SAT_HI)      res_d[l] = SAT_HI[DW-1:0];
      else if (shf < SAT_LO) res_d[l] = SAT_LO[DW-1:0];
      else                   res_d[l] = shf[DW-1:0];
    end

    always_ff @(posedge clk) begin
      if (ld3) res_q[l] <= res_d[l];
    end
  end

  assign out_valid = v3_q;
  assign x0_re     = res_q[0];
  assign x0_im     = res_q[1];
  assign x1_re     = res_q[2];
  assign x1_im     = res_q[3];
endmodule

// File: rtl/r2bf_chk.sv
module r2bf_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [DW-1:0] in_are,
  input logic [DW-1:0] in_aim,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] x0_re,
  input logic [DW-1:0] x0_im,
  input logic [DW-1:0] x1_re,
  input logic [DW-1:0] x1_im
);
  localparam logic [DW-1:0] LIM_HI = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] LIM_LO = {1'b1, {(DW-1){1'b0}}};

  logic [2:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cyc <= 3'd0;
    else if (cyc != 3'd7) cyc <= cyc + 3'd1;
  end

  // observer copy of A travelling with the stall enable
  logic [DW-1:0] a1_re, a1_im, a2_re, a2_im, a3_re, a3_im;
  always_ff @(posedge clk) begin
    if (out_ready) begin
      a1_re <= in_are; a1_im <= in_aim;
      a2_re <= a1_re;  a2_im <= a1_im;
      a3_re <= a2_re;  a3_im <= a2_im;
    end
  end

  logic signed [DW+2:0] d_re, d_im;
  logic nosat_re, nosat_im;
  assign d_re = {{3{x0_re[DW-1]}}, x0_re} + {{3{x1_re[DW-1]}}, x1_re}
              - {{2{a3_re[DW-1]}}, a3_re, 1'b0};
  assign d_im = {{3{x0_im[DW-1]}}, x0_im} + {{3{x1_im[DW-1]}}, x1_im}
              - {{2{a3_im[DW-1]}}, a3_im, 1'b0};
  assign nosat_re = (x0_re != LIM_HI) && (x0_re != LIM_LO) && (x1_re != LIM_HI) && (x1_re != LIM_LO);
  assign nosat_im = (x0_im != LIM_HI) && (x0_im != LIM_LO) && (x1_im != LIM_HI) && (x1_im != LIM_LO);

  AST_LATENCY_THREE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd4 && $past(out_ready, 1) && $past(out_ready, 2) && $past(out_ready, 3))
      |-> (out_valid == $past(in_valid && in_ready, 3))); // R5

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(x0_re) && $stable(x0_im)
                                   && $stable(x1_re) && $stable(x1_im))); // R6

  AST_STALL_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_ready) |-> (!in_ready)); // R6

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc < 3'd3) |-> !out_valid); // R7

  AST_SYM_RE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd4 && out_valid && nosat_re) |-> (d_re == 0 || d_re == 1)); // R8

  AST_SYM_IM: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd4 && out_valid && nosat_im) |-> (d_im == 0 || d_im == 1)); // R8
endmodule

bind r2_butterfly_lp r2bf_chk #(.DW(DW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_are   (in_are),
  .in_aim   (in_aim),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .x0_re    (x0_re),
  .x0_im    (x0_im),
  .x1_re    (x1_re),
  .x1_im    (x1_im)
);

// File: tb/r2_butterfly_lp_tb_top.sv
`timescale 1ns/1ps
module r2_butterfly_lp_tb_top;
  localparam int DW   = 16;
  localparam int NFFT = 16;
  localparam int NTW  = NFFT / 2;
  localparam int IW   = $clog2(NTW);
  localparam int FB   = DW - 1;
  localparam longint VMAX = (longint'(1) << (DW - 1)) - 1;
  localparam longint VMIN = -(longint'(1) << (DW - 1));

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, in_ready, out_valid, out_ready;
  logic [DW-1:0] in_are, in_aim, in_bre, in_bim;
  logic [IW-1:0] in_idx;
  logic [DW-1:0] x0_re, x0_im, x1_re, x1_im;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  r2_butterfly_lp #(.DW(DW), .NFFT(NFFT)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_are(in_are), .in_aim(in_aim), .in_bre(in_bre), .in_bim(in_bim),
    .in_idx(in_idx),
    .out_valid(out_valid), .out_ready(out_ready),
    .x0_re(x0_re), .x0_im(x0_im), .x1_re(x1_re), .x1_im(x1_im)
  );

  // ---------------- reference model from the requirements
  function automatic longint twv(int k, bit sin_part);
    real ang, v;
    ang = 2.0 * 3.141592653589793 * real'(k) / real'(NFFT);
    v = sin_part ? -$sin(ang) : $cos(ang);
    for (int i = 0; i < FB; i++) v = v * 2.0;
    if (v >= 0.0) return longint'($rtoi(v + 0.5));
    return longint'($rtoi(v - 0.5));
  endfunction

  function automatic longint clampv(longint v);
    if (v > VMAX) return VMAX;
    if (v < VMIN) return VMIN;
    return v;
  endfunction

  function automatic longint rnd(longint a, longint p);
    longint t;
    t = (a <<< FB) + p + (longint'(1) <<< (FB - 1));
    return clampv(t >>> FB);
  endfunction

  longint e0r, e0i, e1r, e1i;

  task automatic model(longint ar, longint ai, longint br, longint bi, int k);
    longint c, d, pr, pi;
    c  = twv(k, 1'b0);
    d  = twv(k, 1'b1);
    pr = c * br - d * bi;
    pi = c * bi + d * br;
    e0r = rnd(ar, pr);
    e0i = rnd(ai, pi);
    e1r = rnd(ar, -pr);
    e1i = rnd(ai, -pi);
  endtask

  task automatic check(string req, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sx(logic [DW-1:0] v);
    return longint'($signed(v));
  endfunction

  task automatic check_outs(string req);
    check({req, " out_valid"}, longint'(out_valid), 1);
    check({req, " x0_re"}, sx(x0_re), e0r);
    check({req, " x0_im"}, sx(x0_im), e0i);
    check({req, " x1_re"}, sx(x1_re), e1r);
    check({req, " x1_im"}, sx(x1_im), e1i);
  endtask

  task automatic drive(longint ar, longint ai, longint br, longint bi, int k);
    in_valid = 1'b1;
    in_are   = DW'(ar);
    in_aim   = DW'(ai);
    in_bre   = DW'(br);
    in_bim   = DW'(bi);
    in_idx   = IW'(k);
  endtask

  // one transfer, three edges, sample at the following falling edge
  task automatic run_one(string req, longint ar, longint ai, longint br, longint bi, int k);
    model(ar, ai, br, bi, k);
    @(negedge clk);
    out_ready = 1'b1;
    drive(ar, ai, br, bi, k);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check_outs(req);
  endtask

  // ---------------- scenarios
  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_are = '0; in_aim = '0; in_bre = '0; in_bim = '0; in_idx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 out_valid in reset", longint'(out_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 out_valid idle after reset", longint'(out_valid), 0);
  endtask

  task automatic t_each_index();
    for (int k = 0; k < NTW; k++)
      run_one("R1 index sweep", 1000 - 300 * k, -2000 + 111 * k, 12345 - 2000 * k, -7000 + 1500 * k, k);
  endtask

  task automatic t_identity();
    longint a_r, a_i, b_r, b_i;
    a_r = 1234; a_i = -4321; b_r = -999; b_i = 20000;
    run_one("R4 index0 model", a_r, a_i, b_r, b_i, 0);
    check("R4 x0_re=A+B", sx(x0_re), clampv(a_r + b_r));
    check("R4 x0_im=A+B", sx(x0_im), clampv(a_i + b_i));
    check("R4 x1_re=A-B", sx(x1_re), clampv(a_r - b_r));
    check("R4 x1_im=A-B", sx(x1_im), clampv(a_i - b_i));
  endtask

  task automatic t_fullscale();
    run_one("R9 full-scale neg index0", VMIN, VMIN, VMIN, VMIN, 0);
    check("R9 x0_re clamps low", sx(x0_re), VMIN);
    check("R9 x1_re exact zero", sx(x1_re), 0);
    run_one("R9 full-scale neg quarter turn", VMIN, 0, VMIN, VMIN, NTW / 2);
    run_one("R9 full-scale neg 45deg", VMIN, VMIN, VMIN, VMAX, NTW / 4);
  endtask

  task automatic t_saturate();
    run_one("R3 positive clamp", VMAX, VMAX, VMAX, VMAX, 0);
    check("R3 x0_re clamps high", sx(x0_re), VMAX);
    check("R3 x1_im zero", sx(x1_im), 0);
    run_one("R3 negative clamp", VMIN, VMAX, VMAX, VMIN, 0);
    check("R3 x1_re clamps low", sx(x1_re), VMIN);
  endtask

  task automatic t_rounding();
    run_one("R2 45deg plus one", 0, 0, 1, 0, NTW / 4);
    run_one("R2 45deg minus one", 0, 0, -1, 0, NTW / 4);
    run_one("R2 45deg odd mix", 7, -7, 3, 5, NTW / 4);
  endtask

  task automatic t_random();
    for (int i = 0; i < 300; i++) begin
      longint ar, ai, br, bi;
      ar = longint'($urandom_range(0, 65535)) + VMIN;
      ai = longint'($urandom_range(0, 65535)) + VMIN;
      br = longint'($urandom_range(0, 65535)) + VMIN;
      bi = longint'($urandom_range(0, 65535)) + VMIN;
      run_one("R1 R2 random", ar, ai, br, bi, int'($urandom_range(0, NTW - 1)));
    end
  endtask

  task automatic t_latency_stream();
    longint x0r [4], x0i [4], x1r [4], x1i [4];
    repeat (2) @(negedge clk);
    out_ready = 1'b1;
    for (int n = 0; n < 7; n++) begin
      if (n == 2) check("R5 not early", longint'(out_valid), 0);
      if (n >= 3) begin
        e0r = x0r[n-3]; e0i = x0i[n-3]; e1r = x1r[n-3]; e1i = x1i[n-3];
        check_outs("R5 back-to-back");
      end
      if (n < 4) begin
        model(500 * n - 900, 77 * n, -3000 + 2500 * n, 4000 - 1700 * n, 2 * n + 1);
        x0r[n] = e0r; x0i[n] = e0i; x1r[n] = e1r; x1i[n] = e1i;
        drive(500 * n - 900, 77 * n, -3000 + 2500 * n, 4000 - 1700 * n, 2 * n + 1);
      end else begin
        in_valid = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic t_stall();
    longint h0r;
    run_one("R6 pre-stall", 2222, -3333, 4444, -5555, 3);
    h0r = e0r;
    out_ready = 1'b0;
    drive(-10000, 10000, 9999, -9999, 6);
    #1;
    check("R6 in_ready low", longint'(in_ready), 0);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk);
      @(negedge clk);
      check_outs("R6 held during stall");
    end
    check("R6 x0_re still first result", sx(x0_re), h0r);
    out_ready = 1'b1;
    in_valid  = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R6 stalled offer ignored", longint'(out_valid), 0);
  endtask

  // ---------------- watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_each_index();
    t_identity();
    t_fullscale();
    t_saturate();
    t_rounding();
    t_latency_stream();
    t_stall();
    t_random();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule